// File: doc/BRIEF.md
# Dual-Row Clock Configuration Store

This block keeps the configuration word of a programmable clock generator and decides which stored copy is the active one. The word holds a feedback count, a reference count, an output-divider choice, an oscillator tuning code, a duty-level bit, a power-management mode bit and a power-management timing bit. Three copies of the word exist. Two are one-time rows, each with its own valid bit, that are written by a program strobe. The third is a shadow register that can be rewritten any number of times. During bring-up, the shadow copy lets the frequency be tuned again and again. A row is then committed once the right value is found.

Two static inputs choose how the block behaves. The first selects a frequency-select variant. In that variant the second row holds an alternate configuration, and the `fs` pin chooses between the two rows. In the other variant the second row serves as a second chance to program the part, and it overrides the first row once it is valid. The second static input disables the shadow register completely. The active configuration is registered and read back as separate fields.

Top module: `clkcfg_store`

## Requirements
- R1: While reset is asserted, and right after it, every read-back field reads zero, both rows are unprogrammed, the shadow register holds zero, and `pgm_err` and `cfg_chg` are low.
- R2: A configuration word uses this layout: bits [31:20] feedback count, [19:10] reference count, [9:7] output-divider select, [6:3] tuning code, [2] duty level (1 = CMOS), [1] power-management mode (1 = powerdown), [0] power-management timing (1 = synchronous). When the shadow register is the active source, a word written with `shd_wr` appears on the read-back fields at the second rising edge after the write.
- R3: A `pgm_stb[i]` pulse on an unprogrammed row i captures `pgm_data` and sets that row's valid bit. The row content then stays fixed until reset. When that row becomes the source, the value appears on the read-back at the second rising edge after the strobe.
- R4: The shadow register can be rewritten any number of times, and each write replaces the active value. In the dual-program variant it is the source only while neither row is valid. In the frequency-select variant it is the source while the row picked by `fs` is not valid. Shadow writes never change an active value that comes from a valid row.
- R5: With `shadow_off` high, shadow writes are ignored and the shadow content is kept. The active configuration then comes from the rows, and an unprogrammed row reads as all zeros.
- R6: A program strobe aimed at a row that is already valid leaves that row unchanged. It also sets `pgm_err`, which stays high until reset.
- R7: In the dual-program variant (`fsel_variant` low), row 1 is the source once it is valid, taking priority over row 0. Otherwise row 0 is the source once it is valid.
- R8: In the frequency-select variant, `fs` = 0 selects row 0 and `fs` = 1 selects row 1. A change of `fs` reaches the read-back at the first rising edge that samples the new level. `cfg_chg` is high for exactly the cycle that follows that edge.
- R9: In the dual-program variant, changes of `fs` have no effect on the read-back, and `cfg_chg` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| shadow_off | input | 1 | Disables the shadow register |
| fsel_variant | input | 1 | 1 = frequency-select variant, 0 = dual-program variant |
| fs | input | 1 | Frequency-select pin (row choice in the frequency-select variant) |
| shd_wr | input | 1 | Shadow register write strobe |
| shd_data | input | 32 | Shadow write word (layout of R2) |
| pgm_stb | input | 2 | One-time program strobe, one bit per row |
| pgm_data | input | 32 | Word to program (layout of R2) |
| fb_cnt | output | 12 | Active feedback count |
| ref_cnt | output | 10 | Active reference count |
| odiv_sel | output | 3 | Active output-divider select |
| tune_code | output | 4 | Active oscillator tuning code |
| duty_cmos | output | 1 | Active duty level |
| pm_pwrdown | output | 1 | Active power-management mode |
| pm_sync | output | 1 | Active power-management timing |
| pgm_err | output | 1 | Sticky re-program error |
| cfg_chg | output | 1 | One-cycle pulse after an `fs` switch |

## Verification
The bench builds the block with its default parameters: a two-stage reset synchronizer and a 32-bit word of 12/10/3/4/1/1/1-bit fields. With these widths every field can be read back as one word, so a misplaced field shows up in the first shadow-write check. The bench switches `fsel_variant` and `shadow_off` while the block is running and applies a second reset in the middle of the run. This exercises both variants, the fallback to the shadow register when the chosen row is blank, and the zero content of unprogrammed rows.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  parameter int FB_W   = 12;
  parameter int REF_W  = 10;
  parameter int ODIV_W = 3;
  parameter int TUNE_W = 4;
  parameter int ROWS   = 2;

  typedef struct packed {
    logic [FB_W-1:0]   fb;
    logic [REF_W-1:0]  rf;
    logic [ODIV_W-1:0] odiv;
    logic [TUNE_W-1:0] tune;
    logic              duty_cmos;
    logic              pm_pwrdown;
    logic              pm_sync;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/clkcfg_rst_sync.sv
module clkcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/clkcfg_otp_row.sv
module clkcfg_otp_row
  import clkcfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  cfg_t wdata,
  output cfg_t data,
  output logic valid,
  output logic reject
);
  cfg_t data_q, data_d;
  logic vld_q, vld_d;
  logic burn;

  always_comb begin
    burn   = stb & ~vld_q;
    reject = stb & vld_q;
    data_d = burn ? wdata : data_q;
    vld_d  = vld_q | burn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign data  = data_q;
  assign valid = vld_q;

  // R3: a committed row never changes and never loses its valid bit
  p_row_permanent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> (vld_q && $stable(data_q)));
endmodule

// File: rtl/clkcfg_sel.sv
module clkcfg_sel
  import clkcfg_pkg::*;
(
  input  cfg_t [ROWS-1:0] row_dat,
  input  logic [ROWS-1:0] row_vld,
  input  cfg_t            shadow,
  input  logic            shadow_off,
  input  logic            fsel_variant,
  input  logic            fs,
  output cfg_t            nxt
);
  always_comb begin
    nxt = shadow;
    if (fsel_variant) begin
      if (row_vld[fs] || shadow_off) nxt = row_dat[fs];
    end else begin
      if (row_vld[1])                nxt = row_dat[1];
      else if (row_vld[0] || shadow_off) nxt = row_dat[0];
    end
  end
endmodule

// File: rtl/clkcfg_store.sv
module clkcfg_store
  import clkcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shadow_off,
  input  logic              fsel_variant,
  input  logic              fs,
  input  logic              shd_wr,
  input  logic [CFG_W-1:0]  shd_data,
  input  logic [ROWS-1:0]   pgm_stb,
  input  logic [CFG_W-1:0]  pgm_data,
  output logic [FB_W-1:0]   fb_cnt,
  output logic [REF_W-1:0]  ref_cnt,
  output logic [ODIV_W-1:0] odiv_sel,
  output logic [TUNE_W-1:0] tune_code,
  output logic              duty_cmos,
  output logic              pm_pwrdown,
  output logic              pm_sync,
  output logic              pgm_err,
  output logic              cfg_chg
);
  logic srst_n;
  cfg_t shd_q, shd_d;
  cfg_t cfg_q, cfg_d;
  logic err_q, err_d;
  logic fs_q, fs_d;
  logic chg_q, chg_d;
  logic shd_en;
  cfg_t [ROWS-1:0] row_dat;
  logic [ROWS-1:0] row_vld;
  logic [ROWS-1:0] row_rej;

  clkcfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    clkcfg_otp_row u_row (
      .clk(clk), .rst_n(srst_n), .stb(pgm_stb[i]), .wdata(cfg_t'(pgm_data)),
      .data(row_dat[i]), .valid(row_vld[i]), .reject(row_rej[i])
    );
  end

  clkcfg_sel u_sel (
    .row_dat(row_dat), .row_vld(row_vld), .shadow(shd_q),
    .shadow_off(shadow_off), .fsel_variant(fsel_variant), .fs(fs), .nxt(cfg_d)
  );

  always_comb begin
    shd_en = shd_wr & ~shadow_off;
    shd_d  = shd_en ? cfg_t'(shd_data) : shd_q;
    err_d  = err_q | (|row_rej);
    fs_d   = fs;
    chg_d  = fsel_variant & (fs ^ fs_q);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      shd_q <= '0;
      cfg_q <= '0;
      err_q <= 1'b0;
      fs_q  <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      shd_q <= shd_d;
      cfg_q <= cfg_d;
      err_q <= err_d;
      fs_q  <= fs_d;
      chg_q <= chg_d;
    end
  end

  assign fb_cnt     = cfg_q.fb;
  assign ref_cnt    = cfg_q.rf;
  assign odiv_sel   = cfg_q.odiv;
  assign tune_code  = cfg_q.tune;
  assign duty_cmos  = cfg_q.duty_cmos;
  assign pm_pwrdown = cfg_q.pm_pwrdown;
  assign pm_sync    = cfg_q.pm_sync;
  assign pgm_err    = err_q;
  assign cfg_chg    = chg_q;

  // R4: blank rows in the dual-program variant hand the output to the shadow copy
  p_shadow_src_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (!shadow_off && !fsel_variant && row_vld == '0) |=> (cfg_q == $past(shd_q)));

  // R5: a disabled shadow register keeps its content
  p_shadow_frozen_r5: assert property (@(posedge clk) disable iff (!srst_n)
    shadow_off |=> $stable(shd_q));

  // R6: a strobe on a committed row raises the error flag
  p_reject_flag_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (|(pgm_stb & row_vld)) |=> pgm_err);

  // R6: the error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!srst_n)
    pgm_err |=> pgm_err);

  // R7: a valid second row wins in the dual-program variant
  p_row1_prio_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (!fsel_variant && row_vld[1]) |=> (cfg_q == $past(row_dat[1])));

  // R8: fs picks the active row in the frequency-select variant
  p_fs_row_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (fsel_variant && row_vld[fs]) |=> (cfg_q == $past(row_dat[fs])));

  // R9: no change pulse outside the frequency-select variant
  p_chg_variant_r9: assert property (@(posedge clk) disable iff (!srst_n)
    cfg_chg |-> $past(fsel_variant));
endmodule

// File: tb/clkcfg_store_test.sv
`timescale 1ns/1ps
module clkcfg_store_test;
  logic clk = 1'b0;
  logic rst_n, shadow_off, fsel_variant, fs, shd_wr;
  logic [31:0] shd_data, pgm_data;
  logic [1:0] pgm_stb;
  logic [11:0] fb_cnt;
  logic [9:0] ref_cnt;
  logic [2:0] odiv_sel;
  logic [3:0] tune_code;
  logic duty_cmos, pm_pwrdown, pm_sync, pgm_err, cfg_chg;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic err_exp = 1'b0;

  typedef struct {
    int          due;
    logic [31:0] word;
    logic        chg;
    logic        err;
    string       tag;
  } sb_item_t;
  sb_item_t sb[$];
  sb_item_t it;

  localparam logic [31:0] WA = 32'h1234_5678;
  localparam logic [31:0] WB = 32'hA5C3_0F96;
  localparam logic [31:0] WC = 32'hFFFF_FFFF;
  localparam logic [31:0] WD = 32'h0ABC_1DE5;
  localparam logic [31:0] WE = 32'h7777_0001;
  localparam logic [31:0] WF = 32'h3C3C_3C3C;
  localparam logic [31:0] WG = 32'hDEAD_BEEF;
  localparam logic [31:0] WH = 32'h8001_4007;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkcfg_store uut (
    .clk(clk), .rst_n(rst_n), .shadow_off(shadow_off), .fsel_variant(fsel_variant),
    .fs(fs), .shd_wr(shd_wr), .shd_data(shd_data), .pgm_stb(pgm_stb), .pgm_data(pgm_data),
    .fb_cnt(fb_cnt), .ref_cnt(ref_cnt), .odiv_sel(odiv_sel), .tune_code(tune_code),
    .duty_cmos(duty_cmos), .pm_pwrdown(pm_pwrdown), .pm_sync(pm_sync),
    .pgm_err(pgm_err), .cfg_chg(cfg_chg)
  );

  function automatic logic [31:0] readback();
    return {fb_cnt, ref_cnt, odiv_sel, tune_code, duty_cmos, pm_pwrdown, pm_sync};
  endfunction

  task automatic compare(string tag, logic [31:0] w, logic c, logic e);
    checks++;
    if (readback() !== w || cfg_chg !== c || pgm_err !== e) begin
      errors++;
      $display("FAIL %s got word=%h chg=%b err=%b exp word=%h chg=%b err=%b",
               tag, readback(), cfg_chg, pgm_err, w, c, e);
    end
  endtask

  task automatic expect_at(int lat, logic [31:0] w, logic c, string tag);
    sb_item_t x;
    x.due = cyc + lat; x.word = w; x.chg = c; x.err = err_exp; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shadow_write(logic [31:0] w);
    shd_wr = 1'b1; shd_data = w;
    @(negedge clk);
    shd_wr = 1'b0;
  endtask

  task automatic program_row(int r, logic [31:0] w);
    pgm_stb = 2'b00; pgm_stb[r] = 1'b1; pgm_data = w;
    @(negedge clk);
    pgm_stb = 2'b00;
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      compare(it.tag, it.word, it.chg, it.err);
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    compare("R1", 32'h0, 1'b0, 1'b0);
    err_exp = 1'b0;
    rst_n = 1'b1;
    idle(4);
    compare("R1", 32'h0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; shadow_off = 1'b0; fsel_variant = 1'b0; fs = 1'b0;
    shd_wr = 1'b0; shd_data = '0; pgm_stb = '0; pgm_data = '0;
    idle(1);
    do_reset();

    expect_at(2, WA, 1'b0, "R2"); shadow_write(WA); idle(3);
    expect_at(2, WB, 1'b0, "R4"); shadow_write(WB); idle(3);
    shadow_off = 1'b1; expect_at(2, 32'h0, 1'b0, "R5"); idle(3);
    expect_at(2, 32'h0, 1'b0, "R5"); shadow_write(WC); idle(3);
    shadow_off = 1'b0; expect_at(2, WB, 1'b0, "R5"); idle(3);

    expect_at(2, WD, 1'b0, "R3"); program_row(0, WD); idle(3);
    err_exp = 1'b1;
    expect_at(2, WD, 1'b0, "R6"); program_row(0, WE); idle(3);
    expect_at(2, WD, 1'b0, "R4"); shadow_write(WF); idle(3);
    shadow_off = 1'b1; expect_at(2, WD, 1'b0, "R5"); idle(3);
    shadow_off = 1'b0;
    expect_at(2, WG, 1'b0, "R7"); program_row(1, WG); idle(3);
    fs = 1'b1; expect_at(1, WG, 1'b0, "R9"); expect_at(2, WG, 1'b0, "R9"); idle(3);
    fs = 1'b0; expect_at(1, WG, 1'b0, "R9"); idle(3);

    fsel_variant = 1'b1; expect_at(2, WD, 1'b0, "R8"); idle(3);
    fs = 1'b1; expect_at(1, WG, 1'b1, "R8"); expect_at(2, WG, 1'b0, "R8"); idle(3);
    fs = 1'b0; expect_at(1, WD, 1'b1, "R8"); expect_at(2, WD, 1'b0, "R8"); idle(3);
    expect_at(2, WD, 1'b0, "R6"); program_row(1, WA); idle(3);
    fs = 1'b1; expect_at(1, WG, 1'b1, "R6"); idle(3);
    fs = 1'b0; fsel_variant = 1'b0; idle(3);

    do_reset();
    fsel_variant = 1'b1; expect_at(2, 32'h0, 1'b0, "R8"); idle(3);
    fs = 1'b1;
    expect_at(1, 32'h0, 1'b1, "R8"); expect_at(2, WH, 1'b0, "R4");
    shadow_write(WH); idle(3);
    expect_at(2, WH, 1'b0, "R4"); program_row(0, WD); idle(3);
    fs = 1'b0; expect_at(1, WD, 1'b1, "R8"); expect_at(2, WD, 1'b0, "R8"); idle(3);
    shadow_off = 1'b1; fs = 1'b1;
    expect_at(1, 32'h0, 1'b1, "R5"); expect_at(2, 32'h0, 1'b0, "R5"); idle(3);

    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule